// File: doc/BRIEF.md
# Boot Flash Bank Selector with Single-Cycle Probe Override

This block sits on a 68000-style asynchronous bus and decides which of four banks of a boot flash the two bank-select lines point at. In normal operation the selection is a registered value that firmware loads once from the configuration kept in battery-backed clock RAM. Software running from flash can therefore not simply switch banks: the instruction fetch after the switch would come from the wrong bank.

To let software read the header words of any bank while still executing from the current one, four small probe windows are decoded in the memory map. A read that falls into a window drives the bank lines to that window's bank only while the address strobe of that one bus cycle is asserted; the next cycle sees the registered bank again, with no register write involved. Window bases keep bus address bits 16 and 17 at zero, so the window itself never disturbs the flash address lines A0 to A16. A separate range, 0xE40000 to 0xE7FFFF, is the general flash path used for programming and is kept clear of all windows.

Top module: `flash_bank_sel`

## Requirements
- R1: After reset, with no bus cycle in progress, `bank_sel` is 2'b00 and `flash_cs_n` and `flash_we_n` are both 1.
- R2: A `cfg_load` pulse sampled at a rising clock edge while `as_n` is 1 loads `cfg_bank` into the registered bank, which appears on `bank_sel` after that edge whenever no probe read is in progress.
- R3: A `cfg_load` pulse sampled while `as_n` is 0 is ignored; the registered bank keeps its value.
- R4: A read (`rw_n`=1) with `as_n`=0 and `flash_en`=1 whose address bits 23:16 equal 0xE8, 0xEC, 0xF4 or 0xF8 drives `bank_sel` to 2'b00, 2'b01, 2'b10 or 2'b11 respectively and drives `flash_cs_n` to 0.
- R5: While `as_n` is 1, `bank_sel` equals the registered bank, so a probe override ends with the bus cycle.
- R6: `flash_addr` always equals bus address bits 16:0; at a window base it is 0.
- R7: With `as_n`=0 and `flash_en`=1, an address from 0xE40000 to 0xE7FFFF drives `flash_cs_n` to 0 and `bank_sel` to the registered bank; `flash_we_n` is 0 for a write (`rw_n`=0) and 1 for a read.
- R8: A write into a probe window drives neither `flash_cs_n` nor `flash_we_n` low, leaves `bank_sel` at the registered bank and does not change the registered bank.
- R9: With `flash_en`=0, `flash_cs_n` and `flash_we_n` stay 1 and `bank_sel` stays at the registered bank for every address.
- R10: Any address outside the four windows and the flash path, including the 0xFF0000 region, leaves `flash_cs_n` and `flash_we_n` at 1 and `bank_sel` at the registered bank.
- R11: While `as_n` is 1, `flash_cs_n` and `flash_we_n` are 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the bank register |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 24 | Bus address A23..A0 |
| as_n | input | 1 | Active-low address strobe; low marks a bus cycle |
| rw_n | input | 1 | 1 for read, 0 for write |
| flash_en | input | 1 | Enables all flash decoding |
| cfg_load | input | 1 | Loads `cfg_bank` into the registered bank when idle |
| cfg_bank | input | 2 | Bank value from the clock RAM configuration |
| bank_sel | output | 2 | Flash bank-select lines |
| flash_cs_n | output | 1 | Active-low flash chip select |
| flash_we_n | output | 1 | Active-low flash write enable |
| flash_addr | output | 17 | Flash address A16..A0 |

## Verification
On every cycle the assertions check that an idle strobe forces both strobes high and the bank lines back to the registered value, that a disabled flash blocks every strobe and override, that probe writes stay silent, that no two windows ever match together, and that the registered bank moves only on an idle load. Which window maps to which bank, which address ranges select the flash at all, and the exact 0xFF0000 and off-by-one-window boundaries can only be shown by the bench, which sweeps every value of the top address byte for each registered bank, both directions and both enable settings, and compares against a decode computed from the address arithmetic.

// File: rtl/fbs_pkg.sv
package fbs_pkg;

    // Kind of access the current bus cycle makes to the flash
    typedef enum logic [1:0] {
        ACC_NONE   = 2'd0,
        ACC_REGION = 2'd1,
        ACC_PROBE  = 2'd2
    } acc_kind_e;

    // Default window bases, lowest bank first
    localparam logic [23:0] DFLT_WIN_B0 = 24'hE80000;
    localparam logic [23:0] DFLT_WIN_B1 = 24'hEC0000;
    localparam logic [23:0] DFLT_WIN_B2 = 24'hF40000;
    localparam logic [23:0] DFLT_WIN_B3 = 24'hF80000;

endpackage

// File: rtl/fbs_window_match.sv
module fbs_window_match #(
    parameter int ADDR_W   = 24,
    parameter int NUM_WIN  = 4,
    parameter int WIN_AW   = 16,
    parameter logic [NUM_WIN*ADDR_W-1:0] WIN_BASES = '0
) (
    input  logic [ADDR_W-1:0]  addr,
    output logic [NUM_WIN-1:0] hit
);
    localparam int TAG_W = ADDR_W - WIN_AW;

    for (genvar g = 0; g < NUM_WIN; g++) begin : g_win
        localparam logic [TAG_W-1:0] TAG = WIN_BASES[g*ADDR_W+WIN_AW +: TAG_W];
        assign hit[g] = (addr[ADDR_W-1:WIN_AW] == TAG);
    end
endmodule

// File: rtl/fbs_bank_reg.sv
module fbs_bank_reg #(
    parameter int BANK_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              busy,
    input  logic [BANK_W-1:0] din,
    output logic [BANK_W-1:0] bank
);
    typedef struct packed {
        logic [BANK_W-1:0] bank;
    } state_t;

    state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load && !busy) begin
            st_d.bank = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bank = st_q.bank;

    // R3: a load during a bus cycle leaves the bank untouched
    assert_busy_load_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (bank == $past(bank)));

    // R2: an idle load takes effect at the edge that samples it
    assert_idle_load_applies_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !busy) |=> (bank == $past(din)));

    // R2/R3: without a load the bank never moves
    assert_bank_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(bank));
endmodule

// File: rtl/flash_bank_sel.sv
module flash_bank_sel #(
    parameter int ADDR_W    = 24,
    parameter int FLASH_AW  = 17,
    parameter int NUM_BANKS = 4,
    parameter int WIN_AW    = 16,
    parameter logic [NUM_BANKS*ADDR_W-1:0] WIN_BASES =
        {fbs_pkg::DFLT_WIN_B3, fbs_pkg::DFLT_WIN_B2,
         fbs_pkg::DFLT_WIN_B1, fbs_pkg::DFLT_WIN_B0},
    parameter logic [ADDR_W-1:0] PATH_LO = 24'hE40000,
    parameter logic [ADDR_W-1:0] PATH_HI = 24'hE7FFFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [ADDR_W-1:0]     bus_addr,
    input  logic                  as_n,
    input  logic                  rw_n,
    input  logic                  flash_en,
    input  logic                  cfg_load,
    input  logic [1:0]            cfg_bank,
    output logic [1:0]            bank_sel,
    output logic                  flash_cs_n,
    output logic                  flash_we_n,
    output logic [FLASH_AW-1:0]   flash_addr
);
    import fbs_pkg::*;

    localparam int BANK_W = $clog2(NUM_BANKS);

    logic [NUM_BANKS-1:0] hit;
    logic [BANK_W-1:0]    bank_q;
    logic [BANK_W-1:0]    probe_idx;
    logic                 in_path;
    acc_kind_e            acc;

    fbs_window_match #(
        .ADDR_W   (ADDR_W),
        .NUM_WIN  (NUM_BANKS),
        .WIN_AW   (WIN_AW),
        .WIN_BASES(WIN_BASES)
    ) u_win (
        .addr(bus_addr),
        .hit (hit)
    );

    fbs_bank_reg #(
        .BANK_W(BANK_W)
    ) u_bank (
        .clk  (clk),
        .rst_n(rst_n),
        .load (cfg_load),
        .busy (!as_n),
        .din  (cfg_bank),
        .bank (bank_q)
    );

    always_comb begin
        probe_idx = '0;
        for (int i = 0; i < NUM_BANKS; i++) begin
            if (hit[i]) probe_idx = BANK_W'(i);
        end
    end

    assign in_path = (bus_addr >= PATH_LO) && (bus_addr <= PATH_HI);

    always_comb begin
        acc = ACC_NONE;
        if (!as_n && flash_en) begin
            if (in_path)              acc = ACC_REGION;
            else if ((|hit) && rw_n)  acc = ACC_PROBE;
        end
    end

    assign bank_sel   = (acc == ACC_PROBE) ? probe_idx : bank_q;
    assign flash_cs_n = (acc == ACC_NONE);
    assign flash_we_n = !((acc == ACC_REGION) && !rw_n);
    assign flash_addr = bus_addr[FLASH_AW-1:0];

    // R11: no strobe outside a bus cycle
    assert_strobes_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |-> (flash_cs_n && flash_we_n));

    // R5: the override ends with the bus cycle
    assert_idle_reverts_R5: assert property (@(posedge clk) disable iff (!rst_n)
        as_n |-> (bank_sel == bank_q));

    // R9: disabled flash decodes nothing
    assert_enable_gates_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_en |-> (flash_cs_n && flash_we_n && bank_sel == bank_q));

    // R8: writes into a probe window are silent
    assert_probe_write_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!as_n && (|hit) && !rw_n) |-> (flash_cs_n && flash_we_n && bank_sel == bank_q));

    // R4: windows never overlap each other
    assert_windows_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(hit));

    // R6: the flash address follows the bus during any flash select
    assert_addr_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !flash_cs_n |-> (flash_addr == bus_addr[FLASH_AW-1:0]));
endmodule

// File: tb/sim_flash_bank_sel.sv
module sim_flash_bank_sel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] bus_addr = '0;
    logic        as_n = 1'b1;
    logic        rw_n = 1'b1;
    logic        flash_en = 1'b0;
    logic        cfg_load = 1'b0;
    logic [1:0]  cfg_bank = '0;
    logic [1:0]  bank_sel;
    logic        flash_cs_n;
    logic        flash_we_n;
    logic [16:0] flash_addr;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    logic [1:0] latched = 2'b00;

    always #10 clk = ~clk;

    flash_bank_sel u0 (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .as_n(as_n), .rw_n(rw_n),
        .flash_en(flash_en), .cfg_load(cfg_load), .cfg_bank(cfg_bank),
        .bank_sel(bank_sel), .flash_cs_n(flash_cs_n), .flash_we_n(flash_we_n),
        .flash_addr(flash_addr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int win_of(input logic [23:0] a);
        case (a[23:16])
            8'hE8: return 0;
            8'hEC: return 1;
            8'hF4: return 2;
            8'hF8: return 3;
            default: return -1;
        endcase
    endfunction

    task automatic load_bank(input logic [1:0] v);
        @(negedge clk);
        as_n = 1'b1; cfg_load = 1'b1; cfg_bank = v;
        @(negedge clk);
        cfg_load = 1'b0;
        latched = v;
        #4;
        chk(bank_sel == v, "R2 idle load", bank_sel, v);
    endtask

    task automatic access(input logic [23:0] a, input bit rd, input bit en);
        int  w;
        bit  path, probe;
        logic [1:0] eb;
        bit ecs, ewe;
        string tag;
        w = win_of(a);
        path  = (a >= 24'hE40000) && (a <= 24'hE7FFFF);
        probe = (w >= 0) && rd && en;
        ecs = !(en && (path || probe));
        ewe = !(en && path && !rd);
        eb  = probe ? w[1:0] : latched;
        if (!en)                 tag = "R9";
        else if (path)           tag = "R7";
        else if (w >= 0 && !rd)  tag = "R8";
        else if (w >= 0)         tag = "R4";
        else                     tag = "R10";
        @(negedge clk);
        bus_addr = a; rw_n = rd; flash_en = en; as_n = 1'b0;
        #4;
        chk(bank_sel == eb, {tag, " bank"}, bank_sel, eb);
        chk(flash_cs_n == ecs, {tag, " cs"}, flash_cs_n, ecs);
        chk(flash_we_n == ewe, {tag, " we"}, flash_we_n, ewe);
        chk(flash_addr == a[16:0], "R6 flash addr", flash_addr, a[16:0]);
        @(negedge clk);
        as_n = 1'b1;
        #4;
        chk(bank_sel == latched, "R5 revert", bank_sel, latched);
        chk(flash_cs_n && flash_we_n, "R11 idle strobes", {flash_cs_n, flash_we_n}, 2'b11);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++; checks++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #4;
        chk(bank_sel == 2'b00, "R1 reset bank", bank_sel, 0);
        chk(flash_cs_n && flash_we_n, "R1 reset strobes", {flash_cs_n, flash_we_n}, 2'b11);

        // R6: window base gives flash address zero
        access(24'hF40000, 1'b1, 1'b1);
        chk(1'b1, "R6", 0, 0);

        for (int l = 0; l < 4; l++) begin
            load_bank(l[1:0]);
            for (int t = 0; t < 256; t++) begin
                for (int d = 0; d < 2; d++) begin
                    for (int e = 0; e < 2; e++) begin
                        logic [15:0] off;
                        off = 16'((t * 16'h1357 + l * 16'h0101) & 16'hFFFF);
                        access({t[7:0], off}, d[0], e[0]);
                    end
                end
            end
            // R8: probe writes left the registered bank intact
            access(24'h000000, 1'b1, 1'b1);
            // R3: load during a bus cycle is ignored
            @(negedge clk);
            bus_addr = 24'h123456; as_n = 1'b0; rw_n = 1'b1; flash_en = 1'b1;
            cfg_load = 1'b1; cfg_bank = ~l[1:0];
            @(negedge clk);
            cfg_load = 1'b0; as_n = 1'b1;
            #4;
            chk(bank_sel == latched, "R3 busy load", bank_sel, latched);
        end

        // R10 explicit boundaries
        access(24'hFF0000, 1'b1, 1'b1);
        access(24'hE3FFFF, 1'b0, 1'b1);
        access(24'hE80000 + 24'h10000, 1'b1, 1'b1);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule